// File: doc/BRIEF.md
# Valid-Bit Command Ring Consumer

This block is the hardware end of an eight-slot command ring. Software writes fixed-size entries, each with a verb byte and a payload word, into the block's slot storage. The block then takes them out strictly in slot order, one per clock at most. Each consumed entry appears for one cycle on an output stream.

Software picks one of three ways to announce new work. In the first two, software writes a producer index, and each of the two modes accepts that write at its own register address. In the third mode no index is written. Instead, the top bit of each entry's verb byte acts as a valid flag, and the expected value of that flag flips every time the consumer wraps from the last slot back to slot 0.

Software can read the consumer index at any time, together with its wrap phase. Software can also set a fill threshold. After each consumption, the block raises a sticky interrupt when the fill left behind is at or below that threshold.

Top module: `cmd_ring_consumer`

## Requirements
- R1: After reset, the consumer index and its phase read 0 (address 2), the fill reads 0 (address 6), the mode reads 0 (address 4), `irq` is low and `out_valid` is low.
- R2: In mode 2, the slot at the consumer index is consumed when bit 7 of its verb equals the inverse of the consumer phase, so the flag is 1 on the first lap. A slot whose bit 7 does not match is not consumed, and the consumer index holds.
- R3: The consumer index reads as {phase in bit 3, slot in bits 2:0}. Advancing from slot 7 to slot 0 toggles the phase, which flips the polarity expected in mode 2.
- R4: In mode 0, a write to address 0 sets the producer index {phase bit 3, slot bits 2:0}. In this mode a write to address 1 is ignored, and entries are consumed one per cycle until the consumer slot equals the producer slot.
- R5: In mode 1, the roles of addresses 0 and 1 are swapped: address 1 is accepted and address 0 is ignored.
- R6: Each consumption gives exactly one cycle of `out_valid`. During that cycle the block presents the slot number, verb and payload stored in that slot, and the consumer index advances by exactly one.
- R7: Address 6 reads the fill, which is (producer slot minus consumer slot) modulo 8.
- R8: The threshold register at address 3 (bits 2:0) reads back what was written.
- R9: After a consumption, if the fill left is at or below the threshold, `irq` sets. It stays set until a write to address 5 with bit 0 set. Address 5 bit 0 reads `irq`.
- R10: In mode 3, no entry is consumed.
- R11: In mode 2, the producer index follows the consumer index on each consumption, so the fill reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ent_we | input | 1 | Slot storage write strobe |
| ent_slot | input | 3 | Slot being written |
| ent_verb | input | 8 | Verb byte; bit 7 is the valid flag |
| ent_payload | input | 32 | Entry payload |
| out_valid | output | 1 | A consumed entry is presented |
| out_slot | output | 3 | Slot of the consumed entry |
| out_verb | output | 8 | Verb of the consumed entry |
| out_payload | output | 32 | Payload of the consumed entry |
| irq | output | 1 | Sticky fill-threshold interrupt |

## Verification
The properties assume that software never lets the producer get more than seven entries ahead of the consumer. They also assume that, in valid-bit mode, software only rewrites the slot under the consumer index, so that no slot ahead of it ever carries the polarity of the current lap. The stimulus keeps within these limits. In valid-bit mode it writes exactly at the consumer slot tracked by the bench model. In the index modes it moves the producer index at most three slots ahead. The properties also take the mode to be set through register writes only while the ring is drained, and every mode change in the bench is made in that state.

// File: rtl/crc_pkg.sv
package crc_pkg;

    typedef enum logic [1:0] {
        MODE_IDX_UC = 2'd0,
        MODE_IDX_C  = 2'd1,
        MODE_VBIT   = 2'd2,
        MODE_HALT   = 2'd3
    } prod_mode_e;

    localparam int A_PROD_UC = 0;
    localparam int A_PROD_C  = 1;
    localparam int A_CONS    = 2;
    localparam int A_THRESH  = 3;
    localparam int A_MODE    = 4;
    localparam int A_STATUS  = 5;
    localparam int A_FILL    = 6;

endpackage

// File: rtl/crc_slot_store.sv
module crc_slot_store #(
    parameter int IDX_W  = 3,
    parameter int VERB_W = 8,
    parameter int PAY_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [VERB_W-1:0] wr_verb,
    input  logic [PAY_W-1:0]  wr_pay,
    input  logic [IDX_W-1:0]  rd_slot,
    output logic [VERB_W-1:0] rd_verb,
    output logic [PAY_W-1:0]  rd_pay
);
    localparam int SLOTS = 1 << IDX_W;

    logic [VERB_W-1:0] verb_q [SLOTS];
    logic [PAY_W-1:0]  pay_q  [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                verb_q[g] <= '0;
                pay_q[g]  <= '0;
            end else if (wr_en && wr_slot == IDX_W'(g)) begin
                verb_q[g] <= wr_verb;
                pay_q[g]  <= wr_pay;
            end
        end
    end

    assign rd_verb = verb_q[rd_slot];
    assign rd_pay  = pay_q[rd_slot];
endmodule

// File: rtl/crc_avail.sv
module crc_avail
    import crc_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int VERB_W = 8
) (
    input  prod_mode_e        mode,
    input  logic [IDX_W-1:0]  cons_slot,
    input  logic              cons_phase,
    input  logic [IDX_W-1:0]  prod_slot,
    input  logic [VERB_W-1:0] head_verb,
    output logic              take
);
    localparam int VBIT_POS = VERB_W - 1;

    always_comb begin
        unique case (mode)
            MODE_IDX_UC, MODE_IDX_C: take = (cons_slot != prod_slot);
            MODE_VBIT:               take = (head_verb[VBIT_POS] == ~cons_phase);
            default:                 take = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmd_ring_consumer.sv
module cmd_ring_consumer
    import crc_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int VERB_W = 8,
    parameter int PAY_W  = 32,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ent_we,
    input  logic [IDX_W-1:0]  ent_slot,
    input  logic [VERB_W-1:0] ent_verb,
    input  logic [PAY_W-1:0]  ent_payload,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_slot,
    output logic [VERB_W-1:0] out_verb,
    output logic [PAY_W-1:0]  out_payload,
    output logic              irq
);
    localparam int FULL_W = IDX_W + 1;

    typedef struct packed {
        logic              cph;
        logic [IDX_W-1:0]  ci;
        logic              pph;
        logic [IDX_W-1:0]  pi;
        logic [IDX_W-1:0]  thr;
        prod_mode_e        mode;
        logic              irq;
        logic              ov;
        logic [IDX_W-1:0]  oslot;
        logic [VERB_W-1:0] overb;
        logic [PAY_W-1:0]  opay;
    } state_t;

    state_t s_d, s_q;

    logic [VERB_W-1:0] head_verb;
    logic [PAY_W-1:0]  head_pay;
    logic              take;
    logic [FULL_W-1:0] ci_full;
    logic [FULL_W-1:0] pi_full;
    logic [1:0]        mode_bits;
    logic [IDX_W-1:0]  fill_now;
    logic [IDX_W-1:0]  fill_after;

    assign ci_full   = {s_q.cph, s_q.ci};
    assign pi_full   = {s_q.pph, s_q.pi};
    assign mode_bits = s_q.mode;
    assign fill_now  = s_q.pi - s_q.ci;

    crc_slot_store #(.IDX_W(IDX_W), .VERB_W(VERB_W), .PAY_W(PAY_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ent_we),
        .wr_slot (ent_slot),
        .wr_verb (ent_verb),
        .wr_pay  (ent_payload),
        .rd_slot (s_q.ci),
        .rd_verb (head_verb),
        .rd_pay  (head_pay)
    );

    crc_avail #(.IDX_W(IDX_W), .VERB_W(VERB_W)) u_avail (
        .mode       (s_q.mode),
        .cons_slot  (s_q.ci),
        .cons_phase (s_q.cph),
        .prod_slot  (s_q.pi),
        .head_verb  (head_verb),
        .take       (take)
    );

    always_comb begin
        s_d        = s_q;
        s_d.ov     = 1'b0;
        fill_after = '0;
        if (reg_we) begin
            case (reg_addr)
                ADDR_W'(A_PROD_UC): if (s_q.mode == MODE_IDX_UC) {s_d.pph, s_d.pi} = reg_wdata[FULL_W-1:0];
                ADDR_W'(A_PROD_C):  if (s_q.mode == MODE_IDX_C)  {s_d.pph, s_d.pi} = reg_wdata[FULL_W-1:0];
                ADDR_W'(A_THRESH):  s_d.thr  = reg_wdata[IDX_W-1:0];
                ADDR_W'(A_MODE):    s_d.mode = prod_mode_e'(reg_wdata[1:0]);
                ADDR_W'(A_STATUS):  if (reg_wdata[0]) s_d.irq = 1'b0;
                default: ;
            endcase
        end
        if (take) begin
            s_d.ov             = 1'b1;
            s_d.oslot          = s_q.ci;
            s_d.overb          = head_verb;
            s_d.opay           = head_pay;
            {s_d.cph, s_d.ci}  = ci_full + FULL_W'(1);
            if (s_q.mode == MODE_VBIT) begin
                s_d.pph = s_d.cph;
                s_d.pi  = s_d.ci;
            end
            fill_after = s_d.pi - s_d.ci;
            if (fill_after <= s_q.thr) s_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_PROD_UC), ADDR_W'(A_PROD_C): reg_rdata[FULL_W-1:0] = pi_full;
            ADDR_W'(A_CONS):   reg_rdata[FULL_W-1:0] = ci_full;
            ADDR_W'(A_THRESH): reg_rdata[IDX_W-1:0]  = s_q.thr;
            ADDR_W'(A_MODE):   reg_rdata[1:0]        = mode_bits;
            ADDR_W'(A_STATUS): reg_rdata[0]          = s_q.irq;
            ADDR_W'(A_FILL):   reg_rdata[IDX_W-1:0]  = fill_now;
            default: ;
        endcase
    end

    assign out_valid   = s_q.ov;
    assign out_slot    = s_q.oslot;
    assign out_verb    = s_q.overb;
    assign out_payload = s_q.opay;
    assign irq         = s_q.irq;
endmodule

// File: rtl/crc_checks.sv
module crc_checks
    import crc_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W:0]    ci_full,
    input logic [IDX_W:0]    pi_full,
    input logic [1:0]        mode,
    input logic              irq,
    input logic              out_valid,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata
);
    logic clr_wr;
    assign clr_wr = reg_we && reg_addr == ADDR_W'(A_STATUS) && reg_wdata[0];

    // R6: the consumer index only moves together with an output beat
    p_move_with_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ci_full != $past(ci_full)) |-> out_valid);

    // R6: one beat advances the index by exactly one
    p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ci_full == $past(ci_full) + 1'b1);

    // R3: landing on slot 0 flips the phase
    p_wrap_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ci_full[IDX_W-1:0] == '0) |-> ci_full[IDX_W] != $past(ci_full[IDX_W]));

    // R4: index modes stop once the consumer catches the producer
    p_index_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd0 || mode == 2'd1) && ci_full[IDX_W-1:0] == pi_full[IDX_W-1:0]) |=> !out_valid);

    // R10: halted mode consumes nothing
    p_halt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> !out_valid);

    // R9: interrupt holds until cleared
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    // R11: valid-bit mode keeps producer equal to consumer
    p_vbit_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd2 && out_valid) |-> pi_full == ci_full);
endmodule

bind cmd_ring_consumer crc_checks #(.IDX_W(IDX_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ci_full   (ci_full),
    .pi_full   (pi_full),
    .mode      (mode_bits),
    .irq       (irq),
    .out_valid (out_valid),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/cmd_ring_consumer_tb.sv
module cmd_ring_consumer_tb;
    localparam int CLK_P = 10;
    localparam int NROWS = 24;
    // 1 = write the polarity the consumer expects, 0 = write the stale polarity
    localparam bit VB_ROWS [NROWS] = '{1,1,1,0, 1,1,1,1, 0,1,1,1, 1,0,1,1, 1,1,1,1, 0,1,1,1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ent_we = 1'b0;
    logic [2:0]  ent_slot = '0;
    logic [7:0]  ent_verb = '0;
    logic [31:0] ent_payload = '0;
    logic        out_valid;
    logic [2:0]  out_slot;
    logic [7:0]  out_verb;
    logic [31:0] out_payload;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int cnt = 0;               // total consumed entries, model of the consumer index
    logic [7:0]  mverb [8];
    logic [31:0] mpay  [8];

    always #(CLK_P/2) clk = ~clk;

    cmd_ring_consumer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ent_we(ent_we),
        .ent_slot(ent_slot), .ent_verb(ent_verb), .ent_payload(ent_payload),
        .out_valid(out_valid), .out_slot(out_slot), .out_verb(out_verb),
        .out_payload(out_payload), .irq(irq)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(int a, int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(int a, output logic [7:0] d);
        reg_addr = 3'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic ent_put(int slot, logic [7:0] verb, logic [31:0] pay);
        @(negedge clk);
        ent_we = 1'b1; ent_slot = 3'(slot); ent_verb = verb; ent_payload = pay;
        mverb[slot] = verb; mpay[slot] = pay;
        @(negedge clk);
        ent_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // index-mode burst of three entries; good_a accepted, bad_a ignored
    task automatic idx_burst(int md, int good_a, int bad_a, int thr, string rq);
        logic [7:0] rd;
        int target;
        reg_write(4, md);
        for (int k = 0; k < 3; k++) ent_put((cnt + k) % 8, 8'h40 + 8'(k), 32'hB000_0000 + 32'(cnt + k));
        reg_write(5, 1);
        chk("R9 irq cleared", 64'(irq), 64'd0);
        target = (cnt + 3) % 16;
        reg_write(bad_a, target);
        chk({rq, " ignored address gives no output"}, 64'(out_valid), 64'd0);
        reg_read(0, rd);
        chk({rq, " ignored address leaves producer"}, 64'(rd), 64'(cnt % 16));
        reg_write(3, thr);
        reg_read(3, rd);
        chk("R8 threshold readback", 64'(rd), 64'(thr));
        reg_write(good_a, target);
        reg_read(6, rd);
        chk("R7 fill before draining", 64'(rd), 64'd3);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk({rq, " R6 out_valid"}, 64'(out_valid), 64'd1);
            chk("R6 slot", 64'(out_slot), 64'(cnt % 8));
            chk("R6 verb", 64'(out_verb), 64'(mverb[cnt % 8]));
            chk("R6 payload", 64'(out_payload), 64'(mpay[cnt % 8]));
            chk("R9 irq vs threshold", 64'(irq), 64'((2 - k) <= thr));
            cnt++;
        end
        @(negedge clk);
        chk({rq, " stops at producer"}, 64'(out_valid), 64'd0);
        reg_read(2, rd);
        chk("R3 consumer index with phase", 64'(rd), 64'(cnt % 16));
        reg_read(6, rd);
        chk("R7 fill drained", 64'(rd), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        reg_read(2, rd); chk("R1 consumer index", 64'(rd), 64'd0);
        reg_read(6, rd); chk("R1 fill", 64'(rd), 64'd0);
        reg_read(4, rd); chk("R1 mode", 64'(rd), 64'd0);

        // R10 halted mode ignores a matching entry
        reg_write(4, 3);
        ent_put(0, 8'h81, 32'h1234_5678);
        repeat (3) begin
            @(negedge clk);
            chk("R10 no output in halt", 64'(out_valid), 64'd0);
        end
        reg_read(2, rd); chk("R10 consumer holds", 64'(rd), 64'd0);
        ent_put(0, 8'h00, 32'h0);

        // valid-bit mode table walk (R2, R3, R6, R11)
        reg_write(4, 2);
        for (int i = 0; i < NROWS; i++) begin
            logic ph;
            logic vb;
            ph = 1'((cnt / 8) % 2);
            vb = VB_ROWS[i] ? ~ph : ph;
            ent_put(cnt % 8, {vb, 7'(i)}, 32'hA000_0000 + 32'(i));
            @(negedge clk);
            chk("R2 consume on matching flag", 64'(out_valid), 64'(VB_ROWS[i]));
            if (VB_ROWS[i]) begin
                chk("R6 slot", 64'(out_slot), 64'(cnt % 8));
                chk("R6 verb", 64'(out_verb), 64'({vb, 7'(i)}));
                chk("R6 payload", 64'(out_payload), 64'(32'hA000_0000 + 32'(i)));
                cnt++;
            end
            reg_read(2, rd);
            chk("R3 consumer index and phase", 64'(rd), 64'(cnt % 16));
        end
        reg_read(6, rd); chk("R11 fill stays zero", 64'(rd), 64'd0);
        reg_read(0, rd); chk("R11 producer follows", 64'(rd), 64'(cnt % 16));
        reg_read(5, rd); chk("R9 irq status read", 64'(rd), 64'd1);
        chk("R9 irq set in valid-bit mode", 64'(irq), 64'd1);
        repeat (2) @(negedge clk);
        chk("R9 irq sticky", 64'(irq), 64'd1);

        // index modes
        idx_burst(0, 0, 1, 1, "R4");
        idx_burst(1, 1, 0, 0, "R5");

        finish_run();
    end
endmodule